// File: doc/BRIEF.md
# Fixed-Point In-Place Radix-2 FFT Engine

This block computes a complex discrete Fourier transform of a fixed, power-of-two number of points. It works one batch at a time. The host loads the samples one at a time through an indexed write port. It then pulses `start`. A small controller walks every decimation-in-time stage and performs one butterfly per clock on an internal register buffer. When the run ends, `done` is raised and the host reads the spectrum in natural order through an indexed, combinational read port.

All arithmetic is integer. Each butterfly halves both of its outputs, so the whole transform is scaled by 1/N. The twiddle factors are constants scaled by 2^13. Each of the four real products in a complex multiply is shifted right by 13 before the products are summed. Samples are placed at bit-reversed buffer positions as they are written, so no reordering pass is needed at the end.

Top module: `fft_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every buffer entry reads back as 0 on both parts.
- R2: A write with `wr_en` high, accepted while not busy, stores sample index `wr_addr` at buffer position bitrev(`wr_addr`). After a run, read address k holds frequency bin k (natural order).
- R3: `start` sampled high while idle or done makes `busy` high from the next cycle for exactly log2(N)·N/2 cycles (12 at N=8). `done` rises in the cycle `busy` falls. `busy` and `done` are never high together.
- R4: `done` stays high until `start` is sampled. `start` sampled in done launches a new run, and `done` is low in the next cycle.
- R5: `start` sampled while busy is ignored: the run length and the rise of `done` are unchanged.
- R6: Writes presented while busy are ignored and do not alter the results.
- R7: Each butterfly on top value a, bottom value b and twiddle w produces (a + w·b) >>> 1 and (a − w·b) >>> 1, each truncated to 32 bits.
- R8: Twiddle k is round(8192·cos(2πk/N)) for the real part and round(−8192·sin(2πk/N)) for the imaginary part. In each complex product, every one of the four real products is shifted arithmetically right by 13 before it is added or subtracted.
- R9: An impulse input gives outputs of equal magnitude, within rounding. An all-zero input gives all-zero outputs.
- R10: `rd_re` and `rd_im` reflect the buffer entry at `rd_addr` in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Sample write strike |
| wr_addr | input | log2(N) | Natural-order sample index |
| wr_re | input | 32 | Sample real part, signed |
| wr_im | input | 32 | Sample imaginary part, signed |
| start | input | 1 | Launch a transform |
| rd_addr | input | log2(N) | Read index (bin number after a run) |
| busy | output | 1 | Butterflies are running |
| done | output | 1 | Results are valid |
| rd_re | output | 32 | Real part at `rd_addr` |
| rd_im | output | 32 | Imaginary part at `rd_addr` |

## Verification
A `start` sampled at one rising edge shows up as `busy` one cycle later. The last butterfly is written at the twelfth edge after that, and `done` is high in the cycle that follows, with no further latency. A behavioural model of the controller is stepped on every rising edge and compared with `busy` and `done` on every falling edge. The read data are combinational, so the bench changes `rd_addr` on a falling edge and samples 1 ns later, clear of any clock edge. It compares against a fixed-point reference transform computed in the bench from the twiddle and halving rules.

// File: rtl/fft_core.sv
module fft_core #(
  parameter int NPTS = 8,
  parameter int DW   = 32,
  parameter int TWF  = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NPTS)-1:0]     wr_addr,
  input  logic signed [DW-1:0]        wr_re,
  input  logic signed [DW-1:0]        wr_im,
  input  logic                        start,
  input  logic [$clog2(NPTS)-1:0]     rd_addr,
  output logic                        busy,
  output logic                        done,
  output logic signed [DW-1:0]        rd_re,
  output logic signed [DW-1:0]        rd_im
);
  localparam int AW   = $clog2(NPTS);
  localparam int LOGN = AW;
  localparam int HALF = NPTS / 2;
  localparam int BW   = (AW > 1) ? AW - 1 : 1;
  localparam int SW   = (LOGN > 1) ? $clog2(LOGN) : 1;
  localparam int PW   = 2 * DW;
  localparam real SC  = 2.0 ** TWF;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_t;

  state_t state;
  logic [SW-1:0] stg;
  logic [BW-1:0] bfy;
  logic signed [DW-1:0] re_mem [NPTS];
  logic signed [DW-1:0] im_mem [NPTS];
  logic signed [DW-1:0] tw_re [HALF];
  logic signed [DW-1:0] tw_im [HALF];

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  function automatic logic [AW-1:0] rev(input logic [AW-1:0] a);
    for (int i = 0; i < AW; i++) rev[i] = a[AW-1-i];
  endfunction

  for (genvar k = 0; k < HALF; k++) begin : g_tw
    localparam real ANG = 6.283185307179586 * k / NPTS;
    assign tw_re[k] = DW'(rnd(SC * $cos(ANG)));
    assign tw_im[k] = DW'(rnd(-SC * $sin(ANG)));
  end

  logic [AW-1:0] a_top, a_bot;
  logic [BW-1:0] tw_i;
  always_comb begin
    int s_i, j_i;
    s_i   = int'(stg);
    j_i   = int'(bfy) & ((1 << s_i) - 1);
    a_top = AW'(((int'(bfy) >> s_i) << (s_i + 1)) | j_i);
    a_bot = a_top | AW'(1 << s_i);
    tw_i  = BW'(j_i << (LOGN - 1 - s_i));
  end

  logic signed [PW-1:0] ar, ai, br, bi, wr, wi, tr, ti;
  assign ar = PW'(re_mem[a_top]);
  assign ai = PW'(im_mem[a_top]);
  assign br = PW'(re_mem[a_bot]);
  assign bi = PW'(im_mem[a_bot]);
  assign wr = PW'(tw_re[tw_i]);
  assign wi = PW'(tw_im[tw_i]);
  assign tr = ((br * wr) >>> TWF) - ((bi * wi) >>> TWF);
  assign ti = ((br * wi) >>> TWF) + ((bi * wr) >>> TWF);

  logic signed [DW-1:0] top_re, top_im, bot_re, bot_im;
  assign top_re = DW'((ar + tr) >>> 1);
  assign top_im = DW'((ai + ti) >>> 1);
  assign bot_re = DW'((ar - tr) >>> 1);
  assign bot_im = DW'((ai - ti) >>> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      stg   <= '0;
      bfy   <= '0;
      for (int i = 0; i < NPTS; i++) begin
        re_mem[i] <= '0;
        im_mem[i] <= '0;
      end
    end else if (state == ST_RUN) begin
      re_mem[a_top] <= top_re;
      im_mem[a_top] <= top_im;
      re_mem[a_bot] <= bot_re;
      im_mem[a_bot] <= bot_im;
      if (bfy == BW'(HALF - 1)) begin
        bfy <= '0;
        if (stg == SW'(LOGN - 1)) state <= ST_DONE;
        else stg <= stg + 1'b1;
      end else begin
        bfy <= bfy + 1'b1;
      end
    end else begin
      if (wr_en) begin
        re_mem[rev(wr_addr)] <= wr_re;
        im_mem[rev(wr_addr)] <= wr_im;
      end
      if (start) begin
        state <= ST_RUN;
        stg   <= '0;
        bfy   <= '0;
      end
    end
  end

  assign busy  = (state == ST_RUN);
  assign done  = (state == ST_DONE);
  assign rd_re = re_mem[rd_addr];
  assign rd_im = im_mem[rd_addr];
endmodule

// File: rtl/fft_core_chk.sv
module fft_core_chk #(
  parameter int NPTS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  localparam int TOTAL = $clog2(NPTS) * (NPTS / 2);

  int cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else if (busy) cnt <= cnt + 1;
    else cnt <= 0;
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (cnt < TOTAL)); // R3
  AST_RUN_END: assert property (@(posedge clk) disable iff (!rst_n) (busy && cnt == TOTAL - 1) |=> (done && !busy)); // R3
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && !done)); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && cnt < TOTAL - 1) |=> busy); // R5
endmodule

bind fft_core fft_core_chk #(.NPTS(NPTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
);

// File: tb/fft_core_tb.sv
`timescale 1ns/1ps
module fft_core_tb;
  localparam int N = 8;
  localparam int TOTAL = 12;

  logic clk = 0, rst_n = 0, wr_en = 0, start = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic signed [31:0] wr_re = 0, wr_im = 0;
  logic busy, done;
  logic signed [31:0] rd_re, rd_im;

  fft_core u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_re(wr_re), .wr_im(wr_im), .start(start), .rd_addr(rd_addr),
    .busy(busy), .done(done), .rd_re(rd_re), .rd_im(rd_im));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int in_re [N], in_im [N], ex_re [N], ex_im [N];
  longint twr [N/2], twi [N/2];
  int unsigned seed = 32'h1234_5678;

  // behavioural controller model: 0 idle, 1 running, 2 done
  int m_st = 0, m_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_st <= 0; m_cnt <= 0; end
    else if (m_st == 1) begin
      if (m_cnt == TOTAL - 1) begin m_st <= 2; m_cnt <= 0; end
      else m_cnt <= m_cnt + 1;
    end else if (start) begin m_st <= 1; m_cnt <= 0; end
  end

  always @(negedge clk) if (rst_n) begin
    n_cmp++;
    if (busy !== (m_st == 1) || done !== (m_st == 2)) begin
      n_bad++;
      $display("FAIL R3/R4/R5 busy=%0b done=%0b expected busy=%0b done=%0b", busy, done, m_st == 1, m_st == 2);
    end
  end

  function automatic int rev3(input int a);
    return ((a & 1) << 2) | (a & 2) | ((a >> 2) & 1);
  endfunction

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  // R7 R8: fixed-point reference transform
  function automatic void ref_fft();
    longint a_r [N], a_i [N];
    for (int i = 0; i < N; i++) begin a_r[rev3(i)] = in_re[i]; a_i[rev3(i)] = in_im[i]; end
    for (int s = 0; s < 3; s++) begin
      int half = 1 << s;
      for (int b = 0; b < N/2; b++) begin
        int j = b % half;
        int tp = (b / half) * 2 * half + j;
        int bt = tp + half;
        int k = j * (N / (2 * half));
        longint tr = ((a_r[bt] * twr[k]) >>> 13) - ((a_i[bt] * twi[k]) >>> 13);
        longint ti = ((a_r[bt] * twi[k]) >>> 13) + ((a_i[bt] * twr[k]) >>> 13);
        longint sr = a_r[tp] + tr, si = a_i[tp] + ti;
        longint dr = a_r[tp] - tr, di = a_i[tp] - ti;
        a_r[tp] = longint'(int'(sr >>> 1)); a_i[tp] = longint'(int'(si >>> 1));
        a_r[bt] = longint'(int'(dr >>> 1)); a_i[bt] = longint'(int'(di >>> 1));
      end
    end
    for (int i = 0; i < N; i++) begin ex_re[i] = int'(a_r[i]); ex_im[i] = int'(a_i[i]); end
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic load();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = 3'(i); wr_re = in_re[i]; wr_im = in_im[i];
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    ref_fft();
    for (int i = 0; i < N; i++) begin
      @(negedge clk); rd_addr = 3'(i); #1;
      check({tag, " R2 R7 R10 re"}, rd_re, ex_re[i]);
      check({tag, " R2 R7 R10 im"}, rd_im, ex_im[i]);
    end
  endtask

  task automatic run_case(input string tag);
    load(); pulse_start(); wait_done(); read_all(tag);
  endtask

  function automatic int rand_amp();
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) % 4001) - 2000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N/2; k++) begin
      twr[k] = rnd(8192.0 * $cos(6.283185307179586 * k / N));
      twi[k] = rnd(-8192.0 * $sin(6.283185307179586 * k / N));
    end
    check("R8 twiddle 1 re", int'(twr[1]), 5793);
    check("R8 twiddle 2 im", int'(twi[2]), -8192);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    for (int i = 0; i < N; i++) begin
      rd_addr = 3'(i); #1;
      check("R1 R10 reset re", rd_re, 0);
      check("R1 R10 reset im", rd_im, 0);
    end

    // R9 zero input
    for (int i = 0; i < N; i++) begin in_re[i] = 0; in_im[i] = 0; end
    run_case("R9 zero");
    for (int i = 0; i < N; i++) begin
      @(negedge clk); rd_addr = 3'(i); #1;
      check("R9 zero out re", rd_re, 0);
      check("R9 zero out im", rd_im, 0);
    end

    // impulse at index 0: every bin 1000/8
    in_re[0] = 1000;
    run_case("R9 impulse0");
    for (int i = 0; i < N; i++) begin
      @(negedge clk); rd_addr = 3'(i); #1;
      check("R9 impulse0 bin re", rd_re, 125);
    end

    // R9 impulse at index 3: equal magnitude within rounding
    for (int i = 0; i < N; i++) in_re[i] = 0;
    in_re[3] = 1600;
    run_case("R9 impulse3");
    for (int i = 0; i < N; i++) begin
      int mag2;
      @(negedge clk); rd_addr = 3'(i); #1;
      mag2 = rd_re * rd_re + rd_im * rd_im;
      check("R9 impulse3 magnitude", (mag2 > 37000 && mag2 < 43000) ? 1 : 0, 1);
    end

    // R2 constant input lands in bin 0 only
    for (int i = 0; i < N; i++) begin in_re[i] = 800; in_im[i] = -400; end
    run_case("R2 dc");
    @(negedge clk); rd_addr = 0; #1;
    check("R2 dc bin0 re", rd_re, 800);
    check("R2 dc bin0 im", rd_im, -400);

    // R4: done holds with no start
    repeat (5) @(negedge clk);
    check("R4 done holds", done, 1);

    // R7 R8 pseudo-random complex inputs, two patterns
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < N; i++) begin in_re[i] = rand_amp(); in_im[i] = rand_amp(); end
      run_case("R7 R8 random");
    end

    // R4 R5 R6: new inputs loaded while done, start again, then
    // start and writes during the run must be ignored
    for (int i = 0; i < N; i++) begin in_re[i] = rand_amp(); in_im[i] = rand_amp(); end
    load();
    pulse_start();
    check("R4 done cleared", done, 0);
    check("R4 busy after start", busy, 1);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); wr_en = 1; wr_addr = 3'(c); wr_re = 32'sd99999; wr_im = -32'sd77777;
    end
    @(negedge clk); wr_en = 0;
    wait_done();
    read_all("R5 R6 ignored");

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule